// File: doc/BRIEF.md
# Strip-Buffered Image Transposer

The block takes a raster-order stream of 24-bit RGB pixels, one per accepted clock, and re-emits the frame in column-major order. A frame of `IMG_W` columns by `IMG_H` rows leaves as an `IMG_H`-column by `IMG_W`-row frame. Two second instances with swapped geometry undo each other. The block never holds the whole frame on chip. It collects a band of `STRIP_H` complete rows into one of two strip buffers. As soon as that band is complete, it drains the band column by column while the other buffer fills.

Each output beat carries the pixel, a linear write address, and a valid strobe. For the source pixel at row `r`, column `c`, the address is `c*IMG_H + r`. A downstream external-memory writer can therefore place every strip straight into its final position in the transposed frame. Red, green and blue live in three separate 8-bit memories that share one address. The write side arms itself only on a start-of-frame marker. A pause input lets the memory side hold the drain. An error flag reports the moment the fill side runs out of free buffers.

The default geometry is 16x12 with 4-row strips, which keeps the memory small. The production settings are 800x525 with a 35-row strip, and the reverse pass uses 525x800 with a 50-row strip.

Top module: `strip_transpose`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first drained beat, `vld_o`, `eof_o` and `ovf_o` are low.
- R2: Pixels with `vld_i` high produce no output and do not advance the write position in two cases: after reset before the first pixel with `sof_i` high, and after the last pixel of a frame until the next `sof_i`.
- R3: Strips are emitted in order. Within a strip, the output goes column 0 to `IMG_W-1`. Within a column it goes top row to bottom row of the strip. Each `pix_o` equals the input pixel at that row and column. The packing is red [23:16], green [15:8], blue [7:0].
- R4: With every beat, `addr_o` equals `c*IMG_H + r` for the source row `r` (0 at the top of the frame) and column `c`.
- R5: `eof_o` is high on exactly the beat that carries row `IMG_H-1`, column `IMG_W-1`, and is never high without `vld_o`.
- R6: Cycles with `vld_i` low do not move the write position. The next valid pixel lands where the previous one left off.
- R7: `ovf_o` rises on the edge after a strip finishes filling while the other buffer still holds a strip whose last read has not been issued by that edge. `ovf_o` stays high until reset. With `stall_i` low throughout, `ovf_o` never rises.
- R8: A cycle with `stall_i` high issues no read, so `vld_o` is low on the following cycle. The drain then resumes at the next pixel with nothing skipped or repeated.
- R9: A pixel with both `vld_i` and `sof_i` high is always taken as row 0, column 0 of a new frame. A partly filled strip is abandoned. Strips already complete are still drained in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input pixel valid |
| sof_i | input | 1 | Input pixel is the first of a frame |
| pix_i | input | 24 | Input pixel, R/G/B packed |
| stall_i | input | 1 | Hold the drain this cycle |
| vld_o | output | 1 | Output beat valid |
| pix_o | output | 24 | Output pixel |
| addr_o | output | $clog2(IMG_W*IMG_H) | Linear address of the pixel in the transposed frame |
| eof_o | output | 1 | Beat carries the last pixel of the frame |
| ovf_o | output | 1 | Sticky buffer overrun flag |

## Verification
The bench drives frames that exercise gaps, stalls, aborted frames and back-to-back frames. It compares every drained beat against an expected list built from the pixels it sent.

Each kind of wrong internal state shows up at the ports in its own way:
- A write counter that slips, or a lock that arms on the wrong pixel, puts a wrong colour or address on the first beat of the next drained strip. That beat arrives two cycles after the strip's last pixel.
- A wrong bank pointer or strip index corrupts data or addresses of a whole strip at once.
- A wrong read counter is caught on the very beat it produces.
- A full flag that clears too early or too late shows as an early or missing `ovf_o`, or as a strip that is never drained. The bench detects the undrained strip when its expected list fails to empty.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int CH_W  = 8;
  localparam int N_CH  = 3;
  localparam int PIX_W = CH_W * N_CH;

  typedef logic [PIX_W-1:0] pix_t;

  function automatic int bits_for(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tp_wr_ctrl.sv
module tp_wr_ctrl import tp_pkg::*; #(
  parameter  int IMG_W   = 16,
  parameter  int IMG_H   = 12,
  parameter  int STRIP_H = 4,
  localparam int N_STRIP = IMG_H / STRIP_H,
  localparam int CW      = bits_for(IMG_W),
  localparam int RW      = bits_for(STRIP_H),
  localparam int SW      = bits_for(N_STRIP)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic          sof_i,
  output logic          we_o,
  output logic [CW-1:0] col_o,
  output logic [RW-1:0] row_o,
  output logic [SW-1:0] strip_o,
  output logic          strip_done_o
);
  logic          locked_q;
  logic [CW-1:0] col_q, col_e;
  logic [RW-1:0] row_q, row_e;
  logic [SW-1:0] strip_q, strip_e;
  logic          start, acc, lc, lr, ls;

  always_comb begin
    start   = vld_i & sof_i;
    acc     = vld_i & (locked_q | sof_i);
    col_e   = start ? '0 : col_q;
    row_e   = start ? '0 : row_q;
    strip_e = start ? '0 : strip_q;
    lc      = (col_e == CW'(IMG_W - 1));
    lr      = (row_e == RW'(STRIP_H - 1));
    ls      = (strip_e == SW'(N_STRIP - 1));
  end

  assign we_o         = acc;
  assign col_o        = col_e;
  assign row_o        = row_e;
  assign strip_o      = strip_e;
  assign strip_done_o = acc & lc & lr;

  // flat, mutually exclusive update terms keep the increment logic shallow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      col_q    <= '0;
      row_q    <= '0;
      strip_q  <= '0;
    end else begin
      if (acc & ~lc)                 col_q   <= col_e + 1'b1;
      if (acc &  lc)                 col_q   <= '0;
      if (acc &  lc & ~lr)           row_q   <= row_e + 1'b1;
      if (acc &  lc &  lr)           row_q   <= '0;
      if (start & ~lc)               row_q   <= '0;
      if (acc &  lc &  lr & ~ls)     strip_q <= strip_e + 1'b1;
      if (acc &  lc &  lr &  ls)     strip_q <= '0;
      if (start & ~(lc & lr))        strip_q <= '0;
      if (acc &  lc &  lr &  ls)     locked_q <= 1'b0;
      if (start & ~(lc & lr & ls))   locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tp_strip_mem.sv
module tp_strip_mem import tp_pkg::*; #(
  parameter  int DEPTH = 128,
  localparam int AW    = bits_for(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  pix_t          wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output pix_t          rdata_o
);
  // one memory per colour, all sharing the same address
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [CH_W-1:0] mem_q [DEPTH];
    logic [CH_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (we_i) mem_q[waddr_i] <= wdata_i[g*CH_W +: CH_W];
      if (re_i) rd_q <= mem_q[raddr_i];
    end

    assign rdata_o[g*CH_W +: CH_W] = rd_q;
  end
endmodule

// File: rtl/tp_bank_ctrl.sv
module tp_bank_ctrl import tp_pkg::*; #(
  parameter  int IMG_W    = 16,
  parameter  int IMG_H    = 12,
  parameter  int STRIP_H  = 4,
  localparam int N_STRIP  = IMG_H / STRIP_H,
  localparam int CW       = bits_for(IMG_W),
  localparam int RW       = bits_for(STRIP_H),
  localparam int SW       = bits_for(N_STRIP),
  localparam int STRIP_SZ = IMG_W * STRIP_H,
  localparam int MAW      = bits_for(2 * STRIP_SZ),
  localparam int OAW      = bits_for(IMG_W * IMG_H)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           stall_i,
  input  logic           strip_done_i,
  input  logic [SW-1:0]  strip_i,
  output logic           wbank_o,
  output logic           re_o,
  output logic [MAW-1:0] raddr_o,
  output logic           vld_o,
  output logic [OAW-1:0] addr_o,
  output logic           eof_o,
  output logic           ovf_o
);
  logic           wbank_q, rbank_q;
  logic [1:0]     full_q, set_v, clr_v;
  logic [SW-1:0]  sidx_q [2];
  logic [SW-1:0]  cur_sidx;
  logic [CW-1:0]  rcol_q;
  logic [RW-1:0]  rrow_q;
  logic           rd_go, lr, lc, rd_last, ovf_hit;
  logic [OAW-1:0] oaddr;
  logic           vld_q, eof_q, ovf_q;
  logic [OAW-1:0] addr_q;

  always_comb begin
    rd_go    = full_q[rbank_q] & ~stall_i;
    lr       = (rrow_q == RW'(STRIP_H - 1));
    lc       = (rcol_q == CW'(IMG_W - 1));
    rd_last  = rd_go & lr & lc;
    cur_sidx = sidx_q[rbank_q];
    clr_v    = rd_last      ? (2'b01 << rbank_q) : 2'b00;
    set_v    = strip_done_i ? (2'b01 << wbank_q) : 2'b00;
    // the other buffer still owes reads when this strip completes
    ovf_hit  = strip_done_i & full_q[~wbank_q] & ~clr_v[~wbank_q];
    raddr_o  = MAW'(int'(rbank_q) * STRIP_SZ + int'(rrow_q) * IMG_W + int'(rcol_q));
    oaddr    = OAW'(int'(rcol_q) * IMG_H + int'(cur_sidx) * STRIP_H + int'(rrow_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbank_q <= 1'b0;
      rbank_q <= 1'b0;
      full_q  <= '0;
      for (int k = 0; k < 2; k++) sidx_q[k] <= '0;
      rcol_q  <= '0;
      rrow_q  <= '0;
      vld_q   <= 1'b0;
      eof_q   <= 1'b0;
      ovf_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      full_q <= set_v | (full_q & ~clr_v);
      if (strip_done_i) begin
        wbank_q          <= ~wbank_q;
        sidx_q[wbank_q]  <= strip_i;
      end
      if (rd_last) rbank_q <= ~rbank_q;
      if (rd_go & ~lr)       rrow_q <= rrow_q + 1'b1;
      if (rd_go &  lr)       rrow_q <= '0;
      if (rd_go &  lr & ~lc) rcol_q <= rcol_q + 1'b1;
      if (rd_go &  lr &  lc) rcol_q <= '0;
      vld_q <= rd_go;
      eof_q <= rd_last & (cur_sidx == SW'(N_STRIP - 1));
      if (rd_go)   addr_q <= oaddr;
      if (ovf_hit) ovf_q  <= 1'b1;
    end
  end

  assign wbank_o = wbank_q;
  assign re_o    = rd_go;
  assign vld_o   = vld_q;
  assign addr_o  = addr_q;
  assign eof_o   = eof_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/strip_transpose.sv
module strip_transpose import tp_pkg::*; #(
  parameter  int IMG_W    = 16,
  parameter  int IMG_H    = 12,
  parameter  int STRIP_H  = 4,
  localparam int N_STRIP  = IMG_H / STRIP_H,
  localparam int CW       = bits_for(IMG_W),
  localparam int RW       = bits_for(STRIP_H),
  localparam int SW       = bits_for(N_STRIP),
  localparam int STRIP_SZ = IMG_W * STRIP_H,
  localparam int MAW      = bits_for(2 * STRIP_SZ),
  localparam int OAW      = bits_for(IMG_W * IMG_H)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             sof_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             stall_i,
  output logic             vld_o,
  output logic [PIX_W-1:0] pix_o,
  output logic [OAW-1:0]   addr_o,
  output logic             eof_o,
  output logic             ovf_o
);
  logic           we, strip_done, wbank, re;
  logic [CW-1:0]  wcol;
  logic [RW-1:0]  wrow;
  logic [SW-1:0]  wstrip;
  logic [MAW-1:0] waddr, raddr;

  tp_wr_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H), .STRIP_H(STRIP_H)) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vld_i        (vld_i),
    .sof_i        (sof_i),
    .we_o         (we),
    .col_o        (wcol),
    .row_o        (wrow),
    .strip_o      (wstrip),
    .strip_done_o (strip_done)
  );

  assign waddr = MAW'(int'(wbank) * STRIP_SZ + int'(wrow) * IMG_W + int'(wcol));

  tp_strip_mem #(.DEPTH(2 * STRIP_SZ)) u_mem (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (pix_i),
    .re_i    (re),
    .raddr_i (raddr),
    .rdata_o (pix_o)
  );

  tp_bank_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H), .STRIP_H(STRIP_H)) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stall_i      (stall_i),
    .strip_done_i (strip_done),
    .strip_i      (wstrip),
    .wbank_o      (wbank),
    .re_o         (re),
    .raddr_o      (raddr),
    .vld_o        (vld_o),
    .addr_o       (addr_o),
    .eof_o        (eof_o),
    .ovf_o        (ovf_o)
  );
endmodule

// File: rtl/strip_transpose_chk.sv
module strip_transpose_chk #(
  parameter  int IMG_W = 16,
  parameter  int IMG_H = 12,
  localparam int OAW   = tp_pkg::bits_for(IMG_W * IMG_H)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           stall_i,
  input logic           vld_o,
  input logic           eof_o,
  input logic           ovf_o,
  input logic [OAW-1:0] addr_o,
  input logic           strip_done
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!vld_o && !eof_o && !ovf_o);
    end
  end

  p_eof_needs_vld_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> vld_o);

  p_addr_in_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (int'(addr_o) < IMG_W * IMG_H));

  p_stall_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !vld_o);

  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  p_ovf_on_strip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(strip_done));
endmodule

bind strip_transpose strip_transpose_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stall_i    (stall_i),
  .vld_o      (vld_o),
  .eof_o      (eof_o),
  .ovf_o      (ovf_o),
  .addr_o     (addr_o),
  .strip_done (strip_done)
);

// File: tb/strip_transpose_tb.sv
`timescale 1ns/1ps
module strip_transpose_tb;
  localparam int W   = 16;
  localparam int H   = 12;
  localparam int SH  = 4;
  localparam int OAW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, vld_i, sof_i, stall_i;
  logic [23:0] pix_i;
  logic vld_o, eof_o, ovf_o;
  logic [23:0] pix_o;
  logic [OAW-1:0] addr_o;

  strip_transpose #(.IMG_W(W), .IMG_H(H), .STRIP_H(SH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .vld_i(vld_i), .sof_i(sof_i), .pix_i(pix_i),
    .stall_i(stall_i), .vld_o(vld_o), .pix_o(pix_o), .addr_o(addr_o),
    .eof_o(eof_o), .ovf_o(ovf_o)
  );

  typedef struct { logic [23:0] pix; int addr; logic eof; } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0, n_beats = 0, cyc = 0;
  bit mon_en = 0, model_en = 1, done = 0;
  int m_locked = 0, m_c = 0, m_r = 0, pix_seq = 0;
  logic [23:0] img [H][W];
  logic st_q = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_strip(int s);
    for (int c = 0; c < W; c++)
      for (int r = 0; r < SH; r++) begin
        int gr = s * SH + r;
        q.push_back('{img[gr][c], c * H + gr, (gr == H - 1) && (c == W - 1)});
      end
  endtask

  // driver: applies one cycle of stimulus and updates the reference model
  task automatic drive(bit v, bit s, bit st);
    logic [23:0] p;
    @(negedge clk);
    cyc++;
    pix_seq++;
    p = 24'(pix_seq * 40503 + 17);
    vld_i = v; sof_i = s; stall_i = st; pix_i = p;
    if (model_en && v && (m_locked != 0 || s)) begin
      if (s) begin m_locked = 1; m_r = 0; m_c = 0; end
      img[m_r][m_c] = p;
      if (m_c == W - 1 && (m_r % SH) == SH - 1) push_strip(m_r / SH);
      if (m_c == W - 1) begin
        m_c = 0; m_r++;
        if (m_r == H) begin m_r = 0; m_locked = 0; end
      end else m_c++;
    end
  endtask

  task automatic idle(int n, bit st);
    for (int i = 0; i < n; i++) drive(0, 0, st);
  endtask

  // gap: idle cycle after each pixel (R6); stl: stall every 3rd cycle (R8)
  task automatic send(int npix, bit gap, bit stl);
    for (int i = 0; i < npix; i++) begin
      drive(1, i == 0, stl && (cyc % 3 == 0));
      if (gap) drive(0, 0, stl && (cyc % 3 == 0));
    end
  endtask

  task automatic wait_drain(string req);
    for (int i = 0; i < 3000 && q.size() != 0; i++) drive(0, 0, 0);
    idle(4, 0);
    chk(q.size() == 0, req, "expected beats left undelivered", q.size(), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vld_i = 0; sof_i = 0; stall_i = 0; pix_i = '0;
    m_locked = 0; m_c = 0; m_r = 0; q.delete();
    repeat (3) @(negedge clk);
    chk(!vld_o && !eof_o && !ovf_o, "R1", "outputs during reset",
        {vld_o, eof_o, ovf_o}, 0);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) st_q <= stall_i;

  // monitor: pops the scoreboard on every output beat
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (eof_o && !vld_o) chk(0, "R5", "eof without valid", 1, 0);
      if (st_q) chk(!vld_o, "R8", "beat after stall cycle", vld_o, 0);
      if (vld_o) begin
        n_beats++;
        if (q.size() == 0) chk(0, "R2", "unexpected output beat", addr_o, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(pix_o == e.pix, "R3", "pixel", pix_o, e.pix);
          chk(int'(addr_o) == e.addr, "R4", "address", addr_o, e.addr);
          chk(eof_o == e.eof, "R5", "end of frame", eof_o, e.eof);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    chk(0, "WDOG", "watchdog expired", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int b0;
    do_reset();
    mon_en = 1;
    idle(3, 0);
    chk(!vld_o && !eof_o && !ovf_o, "R1", "outputs after reset", {vld_o, eof_o, ovf_o}, 0);

    // R2: pixels before any start of frame are dropped
    b0 = n_beats;
    for (int i = 0; i < 40; i++) drive(1, 0, 0);
    idle(30, 0);
    chk(n_beats == b0, "R2", "beats from pre-sof pixels", n_beats - b0, 0);

    // R3 R4 R5: continuous frame
    send(W * H, 0, 0);
    wait_drain("R3");

    // R2: trailing pixels after a complete frame
    b0 = n_beats;
    for (int i = 0; i < 70; i++) drive(1, 0, 0);
    idle(30, 0);
    chk(n_beats == b0, "R2", "beats from post-frame pixels", n_beats - b0, 0);

    // R6: gaps between pixels
    send(W * H, 1, 0);
    wait_drain("R6");

    // R8: drain stalls combined with gaps
    send(W * H, 1, 1);
    wait_drain("R8");

    // R9: frame aborted after one and a half strips, then a full frame
    send(W * SH + W * SH / 2, 0, 0);
    send(W * H, 0, 0);
    wait_drain("R9");

    // back-to-back frames, odd strip count exercises bank alternation
    send(W * H, 0, 0);
    send(W * H, 0, 0);
    wait_drain("R3");
    chk(ovf_o == 1'b0, "R7", "overflow without stall", ovf_o, 0);

    // R7: drain held off, second strip completes while first is undrained
    mon_en = 0; model_en = 0;
    for (int i = 0; i < W * SH * 2 - 1; i++) drive(1, i == 0, 1);
    drive(0, 0, 1);
    chk(ovf_o == 1'b0, "R7", "overflow before second strip done", ovf_o, 0);
    drive(1, 0, 1);
    drive(0, 0, 1);
    chk(ovf_o == 1'b1, "R7", "overflow after second strip done", ovf_o, 1);
    idle(300, 0);
    chk(ovf_o == 1'b1, "R7", "overflow flag sticky", ovf_o, 1);
    do_reset();
    model_en = 1;
    idle(2, 0);
    chk(ovf_o == 1'b0, "R1", "overflow cleared by reset", ovf_o, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule